// File: doc/BRIEF.md
# Flash Operation Status Readback Generator

This block forms the byte a host receives when it reads a flash device while an embedded program or erase is running or while an erase is suspended. A command sequencer supplies the current operation mode, bit 7 of the byte being programmed, a mask of the sectors chosen for erase, a pulse-limit timeout flag and an erase-window-expired flag. The array supplies its normal read data. On every read strobe the block picks either the array byte or a status byte. A status byte carries the data-polling bit, two toggle bits, the timeout bit and the erase-window bit.

Two toggle registers change state on read strobes. The operation toggle (bit 6) changes on any read while an operation is active. The sector toggle (bit 2) changes only on reads that land in a sector chosen for erase. Both registers clear when a new embedded operation starts. They keep their state when a suspended erase resumes. The read result is registered: it appears on the clock edge that samples the strobe and holds until the next strobe.

Top module: `flash_status_readback`

## Requirements
- R1: After reset `rd_data` is 0x00. A strobe sampled at a clock edge updates `rd_data` at that same edge. Without a strobe, `rd_data` holds its value.
- R2: Mode codes are: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program during erase suspend. In mode 0, and for the unused codes 5 to 7, a read returns `array_q` unchanged.
- R3: In modes 1 and 4, bit 7 of a read is the complement of `poll_ref`.
- R4: In mode 2, bit 7 reads 0. In mode 3, a read in a selected sector returns bit 7 = 1.
- R5: Bit 6 shows the operation toggle. Each strobe in mode 1, 2 or 4 inverts the toggle after the read, whatever the address. In mode 3 the toggle holds.
- R6: The sector of a read is `rd_sector`. It is selected when `sect_sel[rd_sector]` is 1. Bit 2 shows the sector toggle in modes 2 and 3 and reads 0 in modes 1 and 4. Only a strobe in mode 2 or 3 that hits a selected sector inverts the sector toggle after the read.
- R7: Bit 5 equals `limit_hit` in modes 1, 2 and 4, and reads 0 in mode 3.
- R8: Bit 3 equals `window_done` in mode 2 and reads 0 in every other status response.
- R9: In mode 3, a read in an unselected sector returns `array_q` and leaves both toggles unchanged.
- R10: In every status response, bits 4, 1 and 0 read 0.
- R11: Both toggles clear to 0 when the mode changes to 1 or 4, or to 2 from any mode other than 3. The clear applies to a strobe in that same cycle. A change from 3 to 2 (resume) keeps both toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_strobe | input | 1 | One-cycle read request |
| rd_sector | input | SECT_BITS | Sector field of the read address |
| op_mode | input | 3 | Current operation mode code (R2) |
| poll_ref | input | 1 | Bit 7 of the byte being programmed |
| sect_sel | input | 2**SECT_BITS | One bit per sector chosen for erase |
| limit_hit | input | 1 | Program or erase pulse limit exceeded |
| window_done | input | 1 | Erase command window has expired |
| array_q | input | 8 | Array data for the read address |
| rd_data | output | 8 | Registered read result |

## Verification
The assertions assume that reset is held for more than one clock. They also assume that `op_mode` and the flag inputs are stable across the edge that samples a strobe, so each registered result can be compared with the inputs of the previous cycle. The bench holds reset for several cycles and changes every input only at the falling clock edge. It changes modes only in cycles without a strobe, apart from the one deliberate same-cycle clear. It sweeps every mode code, every sector, three selection masks and all four flag combinations. Expected bytes come from a small arithmetic model of the two toggles.

// File: rtl/fsr_pkg.sv
// Package: shared mode codes, status bit positions and mode-class helpers
// for the flash status readback generator.
// Assumes: the mode code arrives as a 3-bit field; codes above 4 mean idle.
package fsr_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE      = 3'd0,
        MODE_PROG      = 3'd1,
        MODE_ERASE     = 3'd2,
        MODE_SUSP      = 3'd3,
        MODE_SUSP_PROG = 3'd4
    } op_mode_e;

    localparam int DATA_W      = 8;
    localparam int POS_POLL    = 7;
    localparam int POS_OP_TOG  = 6;
    localparam int POS_LIMIT   = 5;
    localparam int POS_WINDOW  = 3;
    localparam int POS_SEC_TOG = 2;

    // Program-type modes: polling reference is valid.
    function automatic logic is_prog(input logic [2:0] m);
        return (m == MODE_PROG) || (m == MODE_SUSP_PROG);
    endfunction

    // Erase-type modes: sector toggle is meaningful.
    function automatic logic is_erase(input logic [2:0] m);
        return (m == MODE_ERASE) || (m == MODE_SUSP);
    endfunction

    // Modes in which an operation is actively running.
    function automatic logic is_running(input logic [2:0] m);
        return is_prog(m) || (m == MODE_ERASE);
    endfunction

endpackage

// File: rtl/fsr_sector_match.sv
// Sector match: reports whether the sector named by a read lies in the
// erase selection mask.
// Assumes: one mask bit per sector, indexed by the sector number.
module fsr_sector_match #(
    parameter int SECT_BITS = 3
) (
    input  logic [SECT_BITS-1:0]    rd_sector,
    input  logic [(1<<SECT_BITS)-1:0] sect_sel,
    output logic                    in_sel
);
    localparam int NUM_SECT = 1 << SECT_BITS;

    logic [NUM_SECT-1:0] hit;

    // One comparator per sector; the results are ORed.
    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        assign hit[g] = sect_sel[g] && (rd_sector == SECT_BITS'(g));
    end

    assign in_sel = |hit;

endmodule

// File: rtl/fsr_toggle_bank.sv
// Toggle bank: a row of toggle registers. Each one inverts when its advance
// strobe is high. A shared clear forces the value seen this cycle to 0.
// Assumes: clear and advance may coincide; the cleared value is read and
// then advanced.
module fsr_toggle_bank #(
    parameter int NUM_TOG = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [NUM_TOG-1:0] adv,
    output logic [NUM_TOG-1:0] cur
);
    logic [NUM_TOG-1:0] tog_q;

    for (genvar i = 0; i < NUM_TOG; i++) begin : g_tog
        // Value presented to this cycle's read.
        assign cur[i] = clr ? 1'b0 : tog_q[i];

        // Register update: advance from the presented value.
        always_ff @(posedge clk) begin
            if (!rst_n) tog_q[i] <= 1'b0;
            else        tog_q[i] <= cur[i] ^ adv[i];
        end

        // R5/R6: with no advance and no clear, the toggle keeps its value.
        p_tog_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && !adv[i] && !clr) |=> (tog_q[i] == $past(tog_q[i])));

        // R11: a clear without an advance leaves the toggle at 0.
        p_tog_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && clr && !adv[i]) |=> (tog_q[i] == 1'b0));
    end

endmodule

// File: rtl/fsr_status_mux.sv
// Status mux: builds the status byte for the current mode and chooses
// between it and the array byte. Purely combinational.
// Assumes: toggle values come in already cleared for a new operation.
module fsr_status_mux
    import fsr_pkg::*;
(
    input  logic [2:0]        mode,
    input  logic              in_sel,
    input  logic              poll_ref,
    input  logic              op_tog,
    input  logic              sec_tog,
    input  logic              limit_hit,
    input  logic              window_done,
    input  logic [DATA_W-1:0] array_q,
    output logic [DATA_W-1:0] rd_next,
    output logic              is_status
);
    logic [DATA_W-1:0] status;

    // Assemble the status byte per mode and pick status or array data.
    always_comb begin
        status    = '0;
        is_status = 1'b1;
        case (mode)
            MODE_PROG, MODE_SUSP_PROG: begin
                status[POS_POLL]   = ~poll_ref;
                status[POS_OP_TOG] = op_tog;
                status[POS_LIMIT]  = limit_hit;
            end
            MODE_ERASE: begin
                status[POS_OP_TOG]  = op_tog;
                status[POS_LIMIT]   = limit_hit;
                status[POS_WINDOW]  = window_done;
                status[POS_SEC_TOG] = sec_tog;
            end
            MODE_SUSP: begin
                if (in_sel) begin
                    status[POS_POLL]    = 1'b1;
                    status[POS_OP_TOG]  = op_tog;
                    status[POS_SEC_TOG] = sec_tog;
                end else begin
                    is_status = 1'b0;
                end
            end
            default: is_status = 1'b0;
        endcase
        rd_next = is_status ? status : array_q;
    end

endmodule

// File: rtl/flash_status_readback.sv
// Top: flash operation status readback generator. It registers the read
// result on each strobe, drives the two toggle registers and detects the
// start of a new embedded operation from mode changes.
// Assumes: mode and flags are stable around the edge that samples a strobe.
module flash_status_readback
    import fsr_pkg::*;
#(
    parameter int SECT_BITS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_strobe,
    input  logic [SECT_BITS-1:0]      rd_sector,
    input  logic [2:0]                op_mode,
    input  logic                      poll_ref,
    input  logic [(1<<SECT_BITS)-1:0] sect_sel,
    input  logic                      limit_hit,
    input  logic                      window_done,
    input  logic [7:0]                array_q,
    output logic [7:0]                rd_data
);
    localparam int TOG_OP  = 1;
    localparam int TOG_SEC = 0;

    logic [2:0]  mode_q;
    logic        new_op;
    logic        in_sel;
    logic [1:0]  adv;
    logic [1:0]  tog_cur;
    logic [7:0]  rd_next;
    logic        is_status;

    // Remember the previous mode so that mode changes can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_IDLE;
        else        mode_q <= op_mode;
    end

    // New operation: entering a program mode, or erase other than a resume.
    always_comb begin
        new_op = (op_mode != mode_q) &&
                 (is_prog(op_mode) ||
                  ((op_mode == MODE_ERASE) && (mode_q != MODE_SUSP)));
    end

    fsr_sector_match #(.SECT_BITS(SECT_BITS)) u_match (
        .rd_sector (rd_sector),
        .sect_sel  (sect_sel),
        .in_sel    (in_sel)
    );

    // Advance strobes for the operation and sector toggles.
    always_comb begin
        adv[TOG_OP]  = rd_strobe && is_running(op_mode);
        adv[TOG_SEC] = rd_strobe && is_erase(op_mode) && in_sel;
    end

    fsr_toggle_bank #(.NUM_TOG(2)) u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (new_op),
        .adv   (adv),
        .cur   (tog_cur)
    );

    fsr_status_mux u_mux (
        .mode        (op_mode),
        .in_sel      (in_sel),
        .poll_ref    (poll_ref),
        .op_tog      (tog_cur[TOG_OP]),
        .sec_tog     (tog_cur[TOG_SEC]),
        .limit_hit   (limit_hit),
        .window_done (window_done),
        .array_q     (array_q),
        .rd_next     (rd_next),
        .is_status   (is_status)
    );

    // Capture the read result on a strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_data <= '0;
        else if (rd_strobe) rd_data <= rd_next;
    end

    // R1: no strobe, no change.
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !rd_strobe) |=> $stable(rd_data));

    // R2: idle and unused codes pass array data through.
    p_idle_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rd_strobe && !is_running(op_mode) && (op_mode != MODE_SUSP))
        |=> (rd_data == $past(array_q)));

    // R3: polling bit is inverted while programming.
    p_poll_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rd_strobe && is_prog(op_mode))
        |=> (rd_data[7] == !$past(poll_ref)));

    // R4: erase in progress reads 0 on the polling bit.
    p_poll_erase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rd_strobe && (op_mode == MODE_ERASE)) |=> (rd_data[7] == 1'b0));

    // R4: suspended erase in a selected sector reads 1 on the polling bit.
    p_poll_susp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rd_strobe && (op_mode == MODE_SUSP) && in_sel)
        |=> (rd_data[7] == 1'b1));

    // R7: timeout bit follows the flag while running.
    p_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rd_strobe && is_running(op_mode))
        |=> (rd_data[5] == $past(limit_hit)));

    // R10: unused status bits stay low.
    p_zero_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rd_strobe && is_status)
        |=> (rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));

endmodule

// File: tb/sim_flash_status_readback.sv
module sim_flash_status_readback;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rd_strobe;
    logic [2:0] rd_sector;
    logic [2:0] op_mode;
    logic       poll_ref;
    logic [7:0] sect_sel;
    logic       limit_hit;
    logic       window_done;
    logic [7:0] array_q;
    logic [7:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state.
    logic       m_op_tog  = 1'b0;
    logic       m_sec_tog = 1'b0;
    logic [2:0] m_mode    = 3'd0;

    always #2 clk = ~clk;

    flash_status_readback #(.SECT_BITS(3)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_sector(rd_sector),
        .op_mode(op_mode), .poll_ref(poll_ref), .sect_sel(sect_sel),
        .limit_hit(limit_hit), .window_done(window_done), .array_q(array_q),
        .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] expect_byte(input logic [2:0] m, input logic sel,
                                               input logic t6, input logic t2);
        case (m)
            3'd1, 3'd4: return {~poll_ref, t6, limit_hit, 5'b0};
            3'd2:       return {1'b0, t6, limit_hit, 1'b0, window_done, t2, 2'b0};
            3'd3:       return sel ? {1'b1, t6, 3'b0, t2, 2'b0} : array_q;
            default:    return array_q;
        endcase
    endfunction

    function automatic logic starts(input logic [2:0] nm, input logic [2:0] om);
        return (nm != om) && (nm == 3'd1 || nm == 3'd4 || (nm == 3'd2 && om != 3'd3));
    endfunction

    // Change mode in a cycle without a strobe; the model follows R11.
    task automatic set_mode(input logic [2:0] nm);
        @(negedge clk);
        op_mode = nm;
        if (starts(nm, m_mode)) begin
            m_op_tog  = 1'b0;
            m_sec_tog = 1'b0;
        end
        m_mode = nm;
        @(negedge clk);
    endtask

    // One read: drive at the falling edge, compare after the next rising edge.
    task automatic do_read(input logic [2:0] sec, input string tag);
        logic       sel;
        logic [7:0] exp;
        sel = sect_sel[sec];
        exp = expect_byte(m_mode, sel, m_op_tog, m_sec_tog);
        rd_sector = sec;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        check(tag, rd_data, exp);
        if (m_mode == 3'd1 || m_mode == 3'd2 || m_mode == 3'd4) m_op_tog = ~m_op_tog;
        if ((m_mode == 3'd2 || m_mode == 3'd3) && sel) m_sec_tog = ~m_sec_tog;
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd1, 3'd4: return "R3 R5 R6 R7 R10";
            3'd2:       return "R4 R5 R6 R7 R8 R10";
            3'd3:       return "R4 R5 R6 R9 R10";
            default:    return "R2";
        endcase
    endfunction

    initial begin
        logic [7:0] pats [3];
        logic [7:0] held;
        pats[0] = 8'hA5; pats[1] = 8'h00; pats[2] = 8'hFF;
        rst_n = 1'b0; rd_strobe = 1'b0; rd_sector = '0; op_mode = 3'd0;
        poll_ref = 1'b0; sect_sel = '0; limit_hit = 1'b0; window_done = 1'b0;
        array_q = 8'h5A;
        repeat (4) @(negedge clk);
        check("R1 reset value", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", rd_data, 8'h00);

        // Sweep all mode codes, masks, sectors and flag pairs.
        for (int m = 0; m < 8; m++) begin
            set_mode(3'(m));
            for (int p = 0; p < 3; p++) begin
                sect_sel = pats[p];
                for (int s = 0; s < 8; s++) begin
                    for (int lw = 0; lw < 4; lw++) begin
                        limit_hit   = lw[0];
                        window_done = lw[1];
                        poll_ref    = lw[0] ^ s[0];
                        array_q     = 8'(8'h3C ^ (s * 37 + lw * 11 + m * 5));
                        do_read(3'(s), mode_tag(3'(m)));
                    end
                end
            end
        end

        // R1: the result holds while inputs change and no strobe arrives.
        set_mode(3'd0);
        array_q = 8'h81;
        do_read(3'd0, "R1 R2 capture");
        held = rd_data;
        array_q = 8'h7E; op_mode = 3'd2;
        repeat (3) @(negedge clk);
        check("R1 hold without strobe", rd_data, held);
        op_mode = 3'd0;
        @(negedge clk);
        // Let the model see the idle period correctly.
        m_mode = 3'd0;

        // R11: resume from suspend keeps toggles.
        sect_sel = 8'h02; limit_hit = 1'b0; window_done = 1'b1;
        set_mode(3'd2);
        do_read(3'd1, "R11 erase first");
        do_read(3'd1, "R11 erase second");
        do_read(3'd1, "R11 erase third");
        set_mode(3'd3);
        do_read(3'd1, "R11 suspended");
        set_mode(3'd2);
        do_read(3'd1, "R11 resumed keeps toggles");
        // R11: new program clears both toggles.
        set_mode(3'd1);
        poll_ref = 1'b1;
        do_read(3'd1, "R11 new program cleared");

        // R11: strobe in the same cycle as a start sees cleared toggles.
        do_read(3'd0, "R5 program advance");
        @(negedge clk);
        op_mode = 3'd2; sect_sel = 8'h01;
        rd_sector = 3'd0; rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        check("R11 same-cycle clear", rd_data, {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b0});
        m_mode = 3'd2; m_op_tog = 1'b1; m_sec_tog = 1'b1;
        do_read(3'd0, "R11 advance after clear");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule